// File: doc/BRIEF.md
# Vertical Position Panning Controller

This block decides on which output line the vertical interval of each output field begins. It holds a 9-bit vertical position value. It counts output lines from the leading edge of the input vertical sync and emits a one-cycle trigger on the line whose count equals the held value. Raising the value delays the output vertical sync by one output line per step, which moves the picture up on the screen. Lowering it moves the picture down.

The value can be written in two parts: a low byte and a separate most-significant bit. Each write is clamped to the largest value that the selected field standard allows. That limit is 262 for the 525-line standard and 312 for the 625-line standard. Single-step pan commands move the value by one. At the ends of the range they wrap asymmetrically: stepping up past the limit returns to zero, and stepping down from zero jumps to the limit. A downstream generator uses the trigger to start the equalizing sequence. That waveform is produced outside this block.

Top module: `vpos_pan_ctrl`

## Requirements
- R1: After reset `vpos` is 0 and `vi_trig` is low. No trigger is issued before the first leading edge of `in_vsync`, however many `line_stb` pulses arrive.
- R2: `vpos` is made of a low byte (bits 7:0) and a top bit (bit 8). A write with `wr_sel`=0 replaces bits 7:0 with `wr_data`. A write with `wr_sel`=1 replaces bit 8 with `wr_data[0]`. In both cases the other part is kept.
- R3: A write whose combined result exceeds the limit stores the limit instead. The limit is 262 when `std_625`=0 and 312 when `std_625`=1.
- R4: A pan-up step adds one to `vpos`. When `vpos` is already at or above the current limit, the step sets it to 0.
- R5: A pan-down step subtracts one from `vpos`. When `vpos` is 0, the step loads the current limit.
- R6: When `pan_up` and `pan_dn` are both high in the same cycle, `vpos` does not change. When `wr_en` is high, the write is applied and any pan input in that cycle is ignored.
- R7: The line count is cleared by each rising edge of `in_vsync` and advances by one per `line_stb` pulse. `vi_trig` pulses when the count equals `vpos`. With `vpos`=0 the pulse follows the vsync edge directly. If the field has fewer lines than `vpos`, no pulse is issued.
- R8: `vi_trig` is high for a single cycle and occurs at most once per field. Only a new rising edge of `in_vsync` re-arms it. A new edge arriving mid-field restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vsync | input | 1 | Input vertical sync, leading edge is rising |
| line_stb | input | 1 | One-cycle pulse per output line |
| std_625 | input | 1 | Field standard: 0 = 525-line (limit 262), 1 = 625-line (limit 312) |
| wr_en | input | 1 | Write strobe for the position value |
| wr_sel | input | 1 | Write target: 0 = low byte, 1 = top bit |
| wr_data | input | 8 | Write data (top-bit write uses bit 0) |
| pan_up | input | 1 | Step position up by one |
| pan_dn | input | 1 | Step position down by one |
| vpos | output | 9 | Current vertical position value |
| vi_trig | output | 1 | One-cycle start-of-vertical-interval trigger |

## Verification
The bench builds the block with its default parameters: a 9-bit position and limits of 262 and 312. With these values both wrap points and the clamp can be reached in a few writes. A field of about 270 lines also drives the trigger to the top of the 525-line range. The same position value 262 is stepped under both standards, so a wrap taken from the wrong limit shows up at once. A field shorter than the programmed position shows that no trigger is issued in that case.

// File: rtl/vpos_pkg.sv
`timescale 1ns/1ps
package vpos_pkg;

    // Field tracking states
    typedef enum logic [1:0] {
        FS_WAIT  = 2'd0,   // no vsync edge seen since reset
        FS_COUNT = 2'd1,   // counting lines, trigger armed
        FS_DONE  = 2'd2    // trigger already issued this field
    } field_state_t;

    // Position register update selected each cycle
    typedef enum logic [1:0] {
        PC_HOLD  = 2'd0,
        PC_UP    = 2'd1,
        PC_DOWN  = 2'd2,
        PC_WRITE = 2'd3
    } pos_cmd_t;

endpackage

// File: rtl/vpos_reg.sv
`timescale 1ns/1ps
module vpos_reg
    import vpos_pkg::*;
#(
    parameter int POS_W   = 9,
    parameter int MAX_525 = 262,
    parameter int MAX_625 = 312
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             std_625,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [POS_W-2:0] wr_data,
    input  logic             pan_up,
    input  logic             pan_dn,
    output logic [POS_W-1:0] pos
);
    localparam int LO_W = POS_W - 1;
    localparam logic [POS_W-1:0] LIM_A = POS_W'(MAX_525);
    localparam logic [POS_W-1:0] LIM_B = POS_W'(MAX_625);

    pos_cmd_t         cmd;
    logic [POS_W-1:0] limit;
    logic [POS_W-1:0] cand;
    logic [POS_W-1:0] pos_nxt;

    always_comb begin
        if (wr_en)
            cmd = PC_WRITE;
        else if (pan_up && !pan_dn)
            cmd = PC_UP;
        else if (pan_dn && !pan_up)
            cmd = PC_DOWN;
        else
            cmd = PC_HOLD;
    end

    always_comb begin
        limit = std_625 ? LIM_B : LIM_A;
        cand  = wr_sel ? {wr_data[0], pos[LO_W-1:0]}
                       : {pos[POS_W-1], wr_data};
    end

    always_comb begin
        unique case (cmd)
            PC_HOLD:  pos_nxt = pos;
            PC_UP:    pos_nxt = (pos >= limit) ? '0 : pos + 1'b1;
            PC_DOWN:  pos_nxt = (pos == '0) ? limit : pos - 1'b1;
            PC_WRITE: pos_nxt = (cand > limit) ? limit : cand;
            default:  pos_nxt = pos;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            pos <= '0;
        else
            pos <= pos_nxt;
    end

endmodule

// File: rtl/vpos_field_fsm.sv
`timescale 1ns/1ps
module vpos_field_fsm
    import vpos_pkg::*;
#(
    parameter int POS_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vsync,
    input  logic             line_stb,
    input  logic [POS_W-1:0] pos,
    output logic             vi_trig
);
    localparam int CNT_W = POS_W + 1;
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    field_state_t     state, state_nxt;
    logic             vs_q;
    logic             vs_rise;
    logic             hit;
    logic [CNT_W-1:0] line_cnt;

    assign vs_rise = in_vsync && !vs_q;
    assign hit     = (state == FS_COUNT) && (line_cnt == CNT_W'(pos));

    // next-state logic
    always_comb begin
        state_nxt = state;
        if (vs_rise) begin
            state_nxt = FS_COUNT;
        end else begin
            unique case (state)
                FS_WAIT:  state_nxt = FS_WAIT;
                FS_COUNT: state_nxt = hit ? FS_DONE : FS_COUNT;
                FS_DONE:  state_nxt = FS_DONE;
                default:  state_nxt = FS_WAIT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= FS_WAIT;
        else
            state <= state_nxt;
    end

    // outputs and line counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vs_q     <= 1'b0;
            vi_trig  <= 1'b0;
            line_cnt <= '0;
        end else begin
            vs_q    <= in_vsync;
            vi_trig <= hit && !vs_rise;
            if (vs_rise)
                line_cnt <= '0;
            else if (line_stb && line_cnt != CNT_TOP)
                line_cnt <= line_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/vpos_pan_ctrl.sv
`timescale 1ns/1ps
module vpos_pan_ctrl #(
    parameter int POS_W   = 9,
    parameter int MAX_525 = 262,
    parameter int MAX_625 = 312
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vsync,
    input  logic             line_stb,
    input  logic             std_625,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [POS_W-2:0] wr_data,
    input  logic             pan_up,
    input  logic             pan_dn,
    output logic [POS_W-1:0] vpos,
    output logic             vi_trig
);

    vpos_reg #(
        .POS_W  (POS_W),
        .MAX_525(MAX_525),
        .MAX_625(MAX_625)
    ) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .std_625(std_625),
        .wr_en  (wr_en),
        .wr_sel (wr_sel),
        .wr_data(wr_data),
        .pan_up (pan_up),
        .pan_dn (pan_dn),
        .pos    (vpos)
    );

    vpos_field_fsm #(
        .POS_W(POS_W)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vsync(in_vsync),
        .line_stb(line_stb),
        .pos     (vpos),
        .vi_trig (vi_trig)
    );

endmodule

// File: rtl/vpos_pan_ctrl_chk.sv
`timescale 1ns/1ps
module vpos_pan_ctrl_chk #(
    parameter int POS_W   = 9,
    parameter int MAX_525 = 262,
    parameter int MAX_625 = 312
) (
    input logic             clk,
    input logic             rst_n,
    input logic             std_625,
    input logic             wr_en,
    input logic             pan_up,
    input logic             pan_dn,
    input logic [POS_W-1:0] vpos,
    input logic             vi_trig
);
    localparam logic [POS_W-1:0] LIM_A = POS_W'(MAX_525);
    localparam logic [POS_W-1:0] LIM_B = POS_W'(MAX_625);

    a_r3_write_clamped: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> vpos <= ($past(std_625) ? LIM_B : LIM_A));

    a_r4_up_step: assert property (@(posedge clk) disable iff (!rst_n)
        (pan_up && !pan_dn && !wr_en && vpos < (std_625 ? LIM_B : LIM_A))
        |=> vpos == $past(vpos) + 1'b1);

    a_r4_up_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (pan_up && !pan_dn && !wr_en && vpos >= (std_625 ? LIM_B : LIM_A))
        |=> vpos == '0);

    a_r5_down_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (pan_dn && !pan_up && !wr_en && vpos == '0)
        |=> vpos == ($past(std_625) ? LIM_B : LIM_A));

    a_r6_both_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (pan_up && pan_dn && !wr_en) |=> $stable(vpos));

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        vi_trig |=> !vi_trig);

endmodule

bind vpos_pan_ctrl vpos_pan_ctrl_chk #(
    .POS_W  (POS_W),
    .MAX_525(MAX_525),
    .MAX_625(MAX_625)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .std_625(std_625),
    .wr_en  (wr_en),
    .pan_up (pan_up),
    .pan_dn (pan_dn),
    .vpos   (vpos),
    .vi_trig(vi_trig)
);

// File: tb/vpos_pan_ctrl_test.sv
`timescale 1ns/1ps
module vpos_pan_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_vsync = 1'b0;
    logic       line_stb = 1'b0;
    logic       std_625 = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic       pan_up = 1'b0;
    logic       pan_dn = 1'b0;
    logic [8:0] vpos;
    logic       vi_trig;

    int n_chk = 0;
    int n_fail = 0;
    int strb_cnt = 0;
    int trig_seen = 0;
    int m_pos = 0;
    int exp_q[$];

    always #2.5 clk = ~clk;

    vpos_pan_ctrl uut (
        .clk(clk), .rst_n(rst_n), .in_vsync(in_vsync), .line_stb(line_stb),
        .std_625(std_625), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .pan_up(pan_up), .pan_dn(pan_dn), .vpos(vpos), .vi_trig(vi_trig)
    );

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int limit_of(logic s);
        return s ? 312 : 262;
    endfunction

    // expected position from the requirements R2-R6
    function automatic int model_next(int p, bit up, bit dn, bit we, bit sel,
                                      int d, logic s);
        int mx = limit_of(s);
        int cand;
        if (we) begin
            cand = sel ? (((d & 1) << 8) | (p & 255)) : ((p & 256) | (d & 255));
            return (cand > mx) ? mx : cand;
        end
        if (up && !dn) return (p >= mx) ? 0 : p + 1;
        if (dn && !up) return (p == 0) ? mx : p - 1;
        return p;
    endfunction

    task automatic apply(string tag, bit up, bit dn, bit we, bit sel, int d);
        @(negedge clk);
        pan_up = up; pan_dn = dn; wr_en = we; wr_sel = sel; wr_data = 8'(d);
        m_pos = model_next(m_pos, up, dn, we, sel, d, std_625);
        @(negedge clk);
        pan_up = 0; pan_dn = 0; wr_en = 0; wr_sel = 0; wr_data = '0;
        check(tag, int'(vpos), m_pos);
    endtask

    // driver: one field of n lines, expected trigger pushed to the scoreboard
    task automatic run_field(string tag, int n);
        @(negedge clk);
        in_vsync = 1'b1;
        strb_cnt = 0;
        trig_seen = 0;
        if (m_pos <= n) exp_q.push_back(m_pos);
        repeat (2) @(negedge clk);
        in_vsync = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            line_stb = 1'b1;
            strb_cnt++;
            @(negedge clk);
            line_stb = 1'b0;
            repeat (3) @(negedge clk);
        end
        repeat (3) @(negedge clk);
        check({tag, " pending"}, exp_q.size(), 0);
        check({tag, " R8 triggers in field"}, trig_seen, (m_pos <= n) ? 1 : 0);
        exp_q.delete();
    endtask

    // monitor: pop expected trigger line and compare
    always @(negedge clk) begin
        if (rst_n && vi_trig) begin
            trig_seen++;
            if (exp_q.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL R8 unexpected trigger: actual line %0d expected none",
                         strb_cnt);
            end else begin
                check("R7 trigger line", strb_cnt, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset vpos", int'(vpos), 0);
        check("R1 reset trigger", int'(vi_trig), 0);
        trig_seen = 0;
        for (int i = 0; i < 5; i++) begin
            line_stb = 1'b1;
            @(negedge clk);
            line_stb = 1'b0;
            repeat (2) @(negedge clk);
        end
        check("R1 no trigger before vsync", trig_seen, 0);

        // R2 / R3 writes, 625-line limit
        std_625 = 1'b1;
        apply("R2 low byte write", 0, 0, 1, 0, 5);
        apply("R2 top bit write", 0, 0, 1, 1, 1);
        apply("R3 clamp 312", 0, 0, 1, 0, 255);
        @(negedge clk) std_625 = 1'b0;
        apply("R3 clamp 262", 0, 0, 1, 0, 16);

        // R4 / R5 wraps at 262
        apply("R4 up wrap at 262", 1, 0, 0, 0, 0);
        apply("R4 up step", 1, 0, 0, 0, 0);
        apply("R5 down step", 0, 1, 0, 0, 0);
        apply("R5 down wrap to 262", 0, 1, 0, 0, 0);

        // same value under 625-line limit
        @(negedge clk) std_625 = 1'b1;
        apply("R4 up no wrap under 312", 1, 0, 0, 0, 0);
        apply("R2 top bit clear", 0, 0, 1, 1, 0);
        apply("R2 low byte zero", 0, 0, 1, 0, 0);
        apply("R5 down wrap to 312", 0, 1, 0, 0, 0);
        apply("R4 up wrap at 312", 1, 0, 0, 0, 0);

        // R6
        apply("R6 both pans ignored", 1, 1, 0, 0, 0);
        apply("R6 write beats pan", 1, 0, 1, 0, 9);

        // fields under 525-line standard
        @(negedge clk) std_625 = 1'b0;
        run_field("R7 pos 9", 12);
        apply("R2 set pos 0", 0, 0, 1, 0, 0);
        run_field("R7 pos 0", 4);
        apply("R2 set pos 3", 0, 0, 1, 0, 3);
        run_field("R8 once per field", 20);
        apply("R2 set pos 4", 0, 0, 1, 0, 4);
        run_field("R8 cut short", 2);
        run_field("R8 restarted field", 6);
        apply("R2 top bit for 260", 0, 0, 1, 1, 1);
        apply("R2 low byte for 262", 0, 0, 1, 0, 6);
        run_field("R7 pos 262", 270);

        // long position, short field: no trigger
        @(negedge clk) std_625 = 1'b1;
        apply("R2 set pos 300", 0, 0, 1, 0, 44);
        run_field("R7 pos beyond field", 280);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule